// File: doc/BRIEF.md
# Dual-Path Branch Prefetch Unit

This unit feeds an in-order pipeline's decode stage from a single fixed-latency instruction memory port. It fetches ahead along the sequential address stream and keeps those words in a small tagged buffer. Each word reaches decode as an instruction-register value together with its address.

When decode reports an unconditional branch, the buffered sequential words are dropped and fetching restarts at the target. When decode reports a conditional branch, the buffered sequential words are kept. The target is fetched in the very next memory slot, the one an operand fetch would use, into a second buffer. Sequential fetching then carries on. Decode stays withheld until execute signals that the condition is known. At that point one buffer is kept and the other is dropped, and decode resumes on the chosen path. No guess is made.

A saturating counter of idle decode cycles lets the branch penalties be measured from outside.

Top module: `dpf_branch_prefetch`

## Requirements
- R1: While `rst_n` is low on a clock edge, all buffers and in-flight fetches are cleared, `ir_valid` is low and `stall_cnt` is zero. In the first cycle after reset, a fetch is requested at address 0.
- R2: Without branches, requests go out at consecutive addresses whenever there is room. The word for a request made in cycle t is taken from `imem_rdata` in cycle t+LAT. Words reach decode in address order, one per cycle while available, with `ir_instr` paired to its `ir_pc`.
- R3: For each path, buffered words plus in-flight fetches never exceed DEPTH. No request is issued that would break this.
- R4: When decode sees an unconditional branch (`br_valid`=1, `br_cond`=0 while `ir_valid`=1), the next cycle requests `br_target`. All older sequential words are discarded. The target word reaches decode LAT+2 cycles after the branch (5 at LAT=3), with `ir_valid` low in between.
- R5: When decode sees a conditional branch (`br_cond`=1), the next cycle requests `br_target`. Later requests continue the sequential stream from where it stopped. Words already prefetched are kept.
- R6: From a conditional branch until the cycle after its resolution, `ir_valid` stays low, so no further instruction (and no second branch) is decoded.
- R7: Resolution taken (`cc_valid`=1, `cc_taken`=1) drops the sequential path. Decode continues with the target, then target+1 onward. Decode resumes at the later of the cycle after resolution and LAT+2 cycles after the branch.
- R8: Resolution not taken (`cc_valid`=1, `cc_taken`=0) drops the target word. Decode continues with branch+1 in order in the cycle after resolution, once that word is buffered.
- R9: `cc_valid` has no effect unless a conditional branch is waiting.
- R10: `stall_cnt` increments in every cycle with `ir_valid` low and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_req | output | 1 | Fetch request this cycle |
| imem_addr | output | AW | Fetch word address |
| imem_rdata | input | DW | Word for the request made LAT cycles earlier |
| ir_valid | output | 1 | Instruction register holds a word for decode (consumed the same cycle) |
| ir_pc | output | AW | Address of the instruction register word |
| ir_instr | output | DW | Instruction register word |
| br_valid | input | 1 | Decode reports the current word is a branch |
| br_cond | input | 1 | 1 = conditional, 0 = unconditional |
| br_target | input | AW | Branch target address |
| cc_valid | input | 1 | Execute reports the condition is known |
| cc_taken | input | 1 | 1 = branch taken |
| stall_cnt | output | SW | Saturating count of cycles without a decode word |

## Verification
The assertions take for granted three things about the inputs. Decode raises `br_valid` only in a cycle where `ir_valid` is high. Memory returns the requested word exactly LAT cycles after each request. Execute may raise `cc_valid` at any time, but it matters only while a branch waits. The bench drives branch indications from a program table keyed on the presented `ir_pc`, so they never appear without a word. It returns memory data from its own request history with the fixed delay, and it pulses `cc_valid` both at scheduled resolution points and at arbitrary idle moments to exercise the ignored case.

// File: rtl/dpf_pkg.sv
// Package: shared types of the dual-path prefetch unit.
// Assumes: nothing beyond SystemVerilog 2017.
package dpf_pkg;

    // Decode-side state: streaming, or holding while a conditional branch waits.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WAIT = 1'b1
    } fetch_state_e;

endpackage

// File: rtl/dpf_path_fifo.sv
// Module: tagged word buffer for one fetch path.
// Holds address/word pairs in order; a flush empties it and wins over push/pop.
// Assumes: pop only when not empty, push only when room (guaranteed by issuer).
module dpf_path_fifo #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [AW-1:0] push_pc,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          head_valid,
    output logic [AW-1:0] head_pc,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] pc_mem  [DEPTH];
    logic [DW-1:0] dat_mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write: capture a returning word unless the path is being flushed.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            pc_mem[wr_ptr]  <= push_pc;
            dat_mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy update; reset and flush both empty the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head_valid = (cnt != '0);
    assign head_pc    = pc_mem[rd_ptr];
    assign head_data  = dat_mem[rd_ptr];
    assign count      = cnt;

    // R3: a push never lands in a full buffer.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (push && !pop) |-> (cnt < CW'(DEPTH)));

    // R2: decode never reads an empty buffer.
    a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n || flush)
        pop |-> (cnt != '0));

endmodule

// File: rtl/dpf_tag_pipe.sv
// Module: in-flight fetch tracker for a fixed-latency memory.
// Carries path and address for each request so the word arriving LAT cycles
// later can be steered. Entries of a killed path are dropped, including one
// that returns in the kill cycle.
// Assumes: memory returns data exactly LAT cycles after the request, LAT >= 1.
module dpf_tag_pipe #(
    parameter int AW  = 16,
    parameter int LAT = 3,
    parameter int CW  = $clog2(LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          issue_path,
    input  logic [AW-1:0] issue_pc,
    input  logic [1:0]    kill,
    output logic          ret_valid,
    output logic          ret_path,
    output logic [AW-1:0] ret_pc,
    output logic [CW-1:0] fly0,
    output logic [CW-1:0] fly1
);

    logic [LAT-1:0] vld;
    logic [LAT-1:0] pth;
    logic [AW-1:0]  pcs [LAT];

    // Shift stage: accept a new request and age the older ones, dropping killed paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            vld[0] <= issue;
            for (int i = 1; i < LAT; i++) begin
                vld[i] <= vld[i-1] && !kill[pth[i-1]];
            end
        end
    end

    // Tag stage: path and address travel alongside the valid bits.
    always_ff @(posedge clk) begin
        pth[0] <= issue_path;
        pcs[0] <= issue_pc;
        for (int i = 1; i < LAT; i++) begin
            pth[i] <= pth[i-1];
            pcs[i] <= pcs[i-1];
        end
    end

    // Count requests still outstanding per path, for flow control.
    always_comb begin
        fly0 = '0;
        fly1 = '0;
        for (int i = 0; i < LAT; i++) begin
            if (vld[i] && !pth[i]) fly0 = fly0 + 1'b1;
            if (vld[i] &&  pth[i]) fly1 = fly1 + 1'b1;
        end
    end

    assign ret_valid = vld[LAT-1] && !kill[pth[LAT-1]];
    assign ret_path  = pth[LAT-1];
    assign ret_pc    = pcs[LAT-1];

    // R4: after a path is killed, nothing of that path remains in flight
    // except a request issued in the same cycle.
    a_r4_kill_path0: assert property (@(posedge clk) disable iff (!rst_n)
        (kill[0] && !(issue && !issue_path)) |=> (fly0 == '0));
    a_r4_kill_path1: assert property (@(posedge clk) disable iff (!rst_n)
        (kill[1] && !(issue && issue_path)) |=> (fly1 == '0));

endmodule

// File: rtl/dpf_branch_prefetch.sv
// Module: dual-path branch prefetch unit (top).
// Streams prefetched words to decode. An unconditional branch flushes and
// refetches at the target. A conditional branch keeps the sequential buffer,
// fetches the target into the other buffer in the next slot and holds decode
// until execute resolves the condition.
// Assumes: br_valid only with ir_valid; decode consumes every presented word;
// memory latency fixed at LAT.
module dpf_branch_prefetch #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LAT   = 3,
    parameter int SW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic [DW-1:0] imem_rdata,
    output logic          ir_valid,
    output logic [AW-1:0] ir_pc,
    output logic [DW-1:0] ir_instr,
    input  logic          br_valid,
    input  logic          br_cond,
    input  logic [AW-1:0] br_target,
    input  logic          cc_valid,
    input  logic          cc_taken,
    output logic [SW-1:0] stall_cnt
);
    import dpf_pkg::*;

    localparam int FCW = $clog2(DEPTH + 1);
    localparam int TCW = $clog2(LAT + 1);

    fetch_state_e  state;
    logic          act;
    logic          tgt_pend;
    logic [AW-1:0] tgt_addr;
    logic [AW-1:0] fetch_pc;
    logic [SW-1:0] stall_q;

    logic          f_head_v [2];
    logic [AW-1:0] f_head_pc[2];
    logic [DW-1:0] f_head_d [2];
    logic [FCW-1:0] f_cnt   [2];
    logic          f_push   [2];
    logic          f_pop    [2];
    logic [1:0]    kill;
    logic [TCW-1:0] fly     [2];

    logic          ret_valid;
    logic          ret_path;
    logic [AW-1:0] ret_pc;

    logic          unc_fire, cnd_fire, resolve, res_taken, res_fall;
    logic          iss, iss_path, iss_inline, room_act;
    logic [AW-1:0] iss_pc;

    // Decode-side view of the active buffer.
    assign ir_valid = (state == ST_RUN) && f_head_v[act];
    assign ir_pc    = f_head_pc[act];
    assign ir_instr = f_head_d[act];

    assign unc_fire  = ir_valid && br_valid && !br_cond;
    assign cnd_fire  = ir_valid && br_valid &&  br_cond;
    assign resolve   = (state == ST_WAIT) && cc_valid;
    assign res_taken = resolve &&  cc_taken;
    assign res_fall  = resolve && !cc_taken;
    assign room_act  = (int'(f_cnt[act]) + int'(fly[act])) < DEPTH;

    // Fetch slot arbitration: target first, otherwise sequential when there is room.
    always_comb begin
        iss        = 1'b0;
        iss_inline = 1'b0;
        iss_path   = act;
        iss_pc     = fetch_pc;
        if (unc_fire) begin
            iss = 1'b0;
        end else if (tgt_pend) begin
            if (!res_fall) begin
                iss      = 1'b1;
                iss_path = ~act;
                iss_pc   = tgt_addr;
            end
        end else if (res_taken) begin
            iss = 1'b0;
        end else if (room_act) begin
            iss        = 1'b1;
            iss_inline = 1'b1;
        end
    end

    // Path discard: sequential path on redirect or taken, target path on fall-through.
    always_comb begin
        kill = 2'b00;
        if (unc_fire || res_taken) kill[act]  = 1'b1;
        if (res_fall)              kill[~act] = 1'b1;
    end

    assign imem_req  = iss;
    assign imem_addr = iss_pc;

    dpf_tag_pipe #(.AW(AW), .LAT(LAT), .CW(TCW)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (iss),
        .issue_path (iss_path),
        .issue_pc   (iss_pc),
        .kill       (kill),
        .ret_valid  (ret_valid),
        .ret_path   (ret_path),
        .ret_pc     (ret_pc),
        .fly0       (fly[0]),
        .fly1       (fly[1])
    );

    for (genvar p = 0; p < 2; p++) begin : g_path
        assign f_push[p] = ret_valid && (ret_path == 1'(p));
        assign f_pop[p]  = ir_valid && (act == 1'(p));

        dpf_path_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(FCW)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (kill[p]),
            .push       (f_push[p]),
            .push_pc    (ret_pc),
            .push_data  (imem_rdata),
            .pop        (f_pop[p]),
            .head_valid (f_head_v[p]),
            .head_pc    (f_head_pc[p]),
            .head_data  (f_head_d[p]),
            .count      (f_cnt[p])
        );
    end

    // Sequencing: fetch pointer, branch wait state and active path selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            act      <= 1'b0;
            tgt_pend <= 1'b0;
            tgt_addr <= '0;
            fetch_pc <= '0;
        end else begin
            if (unc_fire)        fetch_pc <= br_target;
            else if (res_taken)  fetch_pc <= tgt_addr + 1'b1;
            else if (iss_inline) fetch_pc <= fetch_pc + 1'b1;

            if (tgt_pend) tgt_pend <= 1'b0;

            if (cnd_fire) begin
                state    <= ST_WAIT;
                tgt_pend <= 1'b1;
                tgt_addr <= br_target;
            end else if (resolve) begin
                state <= ST_RUN;
                if (cc_taken) act <= ~act;
            end
        end
    end

    // Idle-decode counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stall_q <= '0;
        else if (!ir_valid && stall_q != '1) stall_q <= stall_q + 1'b1;
    end

    assign stall_cnt = stall_q;

    // R1: first cycle out of reset requests address 0 with decode idle.
    a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && rst_n) |-> (imem_req && imem_addr == '0 && !ir_valid));

    // R4: unconditional branch redirects the next request and leaves a bubble.
    a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && br_valid && !br_cond) |=>
            (imem_req && imem_addr == $past(br_target) && !ir_valid));

    // R5: conditional branch uses the next slot for its target.
    a_r5_target_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && br_valid && br_cond) |=>
            ((cc_valid && !cc_taken) || (imem_req && imem_addr == $past(br_target))));

    // R6: decode is withheld in the cycle after a conditional branch.
    a_r6_hold_after_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_valid && br_valid && br_cond) |=> !ir_valid);

    // R10: idle cycles advance the counter, busy cycles leave it alone.
    a_r10_stall_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_valid && stall_cnt != '1) |=> (stall_cnt == $past(stall_cnt) + 1'b1));
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ir_valid |=> $stable(stall_cnt));

endmodule

// File: tb/dpf_branch_prefetch_test.sv
module dpf_branch_prefetch_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, DW = 32, DEPTH = 4, LAT = 3, SW = 16;
    localparam int NCYC = 600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_req;
    logic [AW-1:0] imem_addr;
    logic [DW-1:0] imem_rdata = '0;
    logic          ir_valid;
    logic [AW-1:0] ir_pc;
    logic [DW-1:0] ir_instr;
    logic          br_valid = 1'b0, br_cond = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          cc_valid = 1'b0, cc_taken = 1'b0;
    logic [SW-1:0] stall_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpf_branch_prefetch #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .LAT(LAT), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .ir_valid(ir_valid), .ir_pc(ir_pc), .ir_instr(ir_instr),
        .br_valid(br_valid), .br_cond(br_cond), .br_target(br_target),
        .cc_valid(cc_valid), .cc_taken(cc_taken), .stall_cnt(stall_cnt)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int pc);
        logic [15:0] a;
        a = pc[15:0];
        return {a ^ 16'hBEEF, a};
    endfunction

    // Program: branch kind (1 uncond, 2 cond), target, resolve delay, outcome.
    int br_kind[int], br_tgt[int], br_dly[int], br_tk[int];

    // Reference model state.
    typedef struct { int pc; int path; int due; } fly_t;
    int   q[2][$];
    fly_t infl[$];
    int   m_act = 0, m_fpc = 0, m_taddr = 0, m_stall = 0;
    bit   m_wait = 0, m_tpend = 0;
    int   wcnt = 0, cur_dly = 0, cur_tk = 0;
    int   hist[int];

    function automatic int nfly(input int p);
        int n = 0;
        foreach (infl[i]) if (infl[i].path == p) n++;
        return n;
    endfunction

    initial begin
        br_kind[8]   = 1; br_tgt[8]   = 40;
        br_kind[46]  = 2; br_tgt[46]  = 80;  br_dly[46]  = 2; br_tk[46]  = 1;
        br_kind[83]  = 2; br_tgt[83]  = 300; br_dly[83]  = 5; br_tk[83]  = 0;
        br_kind[90]  = 2; br_tgt[90]  = 120; br_dly[90]  = 1; br_tk[90]  = 1;
        br_kind[125] = 2; br_tgt[125] = 200; br_dly[125] = 7; br_tk[125] = 1;
        br_kind[203] = 2; br_tgt[203] = 400; br_dly[203] = 6; br_tk[203] = 0;
        br_kind[210] = 1; br_tgt[210] = 0;
    end

    initial begin
        #(CLK_PERIOD * (NCYC + 200));
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit   gap_open = 0;
        int   g_start = 0, g_kind = 0, g_dly = 0, g_tk = 0, g_bpc = 0, g_tgt = 0;
        bit   spur_prev = 0;
        int   after_cond = -1, after_tgt = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ir_valid == 1'b0, "R1", "ir_valid in reset", ir_valid, 0);
        chk(stall_cnt == '0, "R1", "stall_cnt in reset", stall_cnt, 0);
        rst_n = 1'b1;

        for (int c = 0; c < NCYC; c++) begin
            bit m_irv, unc, cnd, res, rtk, rfl, m_req, inl, spur;
            int m_pc, m_addr, m_path;
            bit fl[2];

            imem_rdata = hist.exists(c - LAT) ? word_of(hist[c - LAT]) : '0;

            m_irv = !m_wait && q[m_act].size() > 0;
            m_pc  = m_irv ? q[m_act][0] : 0;
            chk(ir_valid == m_irv, spur_prev ? "R9" : "R2", "ir_valid", ir_valid, m_irv);
            if (m_irv) begin
                chk(ir_pc == AW'(m_pc), spur_prev ? "R9" : "R2", "ir_pc", ir_pc, m_pc);
                chk(ir_instr == word_of(m_pc), "R2", "ir_instr", ir_instr, word_of(m_pc));
            end
            if (m_wait) chk(ir_valid == 1'b0, "R6", "decode held while waiting", ir_valid, 0);
            chk(stall_cnt == SW'(m_stall), "R10", "stall_cnt", stall_cnt, m_stall);

            // Branch-penalty and path checks at the first decode after a branch.
            if (gap_open && ir_valid) begin
                int exp_gap, exp_pc;
                if (g_kind == 1) begin exp_gap = LAT + 2; exp_pc = g_tgt; end
                else if (g_tk != 0) begin
                    exp_gap = (g_dly + 1 > LAT + 2) ? g_dly + 1 : LAT + 2; exp_pc = g_tgt;
                end else begin exp_gap = g_dly + 1; exp_pc = g_bpc + 1; end
                if (g_kind == 1) begin
                    chk(c - g_start == exp_gap, "R4", "uncond branch cycles", c - g_start, exp_gap);
                    chk(ir_pc == AW'(exp_pc), "R4", "uncond first pc", ir_pc, exp_pc);
                end else if (g_tk != 0) begin
                    chk(c - g_start == exp_gap, "R7", "taken resume cycle", c - g_start, exp_gap);
                    chk(ir_pc == AW'(exp_pc), "R7", "taken first pc", ir_pc, exp_pc);
                end else begin
                    chk(c - g_start == exp_gap, "R8", "fall-through resume cycle", c - g_start, exp_gap);
                    chk(ir_pc == AW'(exp_pc), "R8", "fall-through first pc", ir_pc, exp_pc);
                end
                gap_open = 0;
            end

            // Decode-side inputs from the program table.
            br_valid = m_irv && br_kind.exists(m_pc);
            br_cond  = br_valid && br_kind[m_pc] == 2;
            br_target = br_valid ? AW'(br_tgt[m_pc]) : '0;
            spur = 0;
            if (m_wait) begin
                wcnt++;
                cc_valid = (wcnt == cur_dly);
                cc_taken = (cur_tk != 0);
            end else begin
                spur = (c % 7 == 3);
                cc_valid = spur;
                cc_taken = c[0];
            end
            #1;

            unc = m_irv && br_valid && !br_cond;
            cnd = m_irv && br_valid &&  br_cond;
            res = m_wait && cc_valid;
            rtk = res && cc_taken;
            rfl = res && !cc_taken;
            m_req = 0; inl = 0; m_addr = 0; m_path = m_act;
            if (unc) m_req = 0;
            else if (m_tpend) begin
                if (!rfl) begin m_req = 1; m_addr = m_taddr; m_path = 1 - m_act; end
            end else if (rtk) m_req = 0;
            else if (q[m_act].size() + nfly(m_act) < DEPTH) begin
                m_req = 1; inl = 1; m_addr = m_fpc;
            end
            chk(imem_req == m_req, (c == 0) ? "R1" : "R3", "imem_req", imem_req, m_req);
            if (m_req) chk(imem_addr == AW'(m_addr), (c == 0) ? "R1" : "R2", "imem_addr", imem_addr, m_addr);
            if (c == after_cond)
                chk(imem_req && imem_addr == AW'(after_tgt), "R5", "target in next slot", imem_addr, after_tgt);

            if (br_valid && m_irv) begin
                gap_open = 1; g_start = c; g_kind = br_kind[m_pc]; g_bpc = m_pc; g_tgt = br_tgt[m_pc];
                g_dly = cnd ? br_dly[m_pc] : 0; g_tk = cnd ? br_tk[m_pc] : 0;
                if (cnd) begin after_cond = c + 1; after_tgt = br_tgt[m_pc]; end
            end

            // Advance the reference model across the clock edge.
            if (m_req) hist[c] = m_addr;
            fl[m_act] = unc || rtk;
            fl[1 - m_act] = rfl;
            if (m_irv) void'(q[m_act].pop_front());
            for (int p = 0; p < 2; p++) if (fl[p]) q[p].delete();
            for (int i = 0; i < infl.size(); i++)
                if (infl[i].due == c && !fl[infl[i].path]) q[infl[i].path].push_back(infl[i].pc);
            for (int i = infl.size() - 1; i >= 0; i--)
                if (infl[i].due == c || fl[infl[i].path]) infl.delete(i);
            if (m_req) infl.push_back('{m_addr, m_path, c + LAT});
            if (unc) m_fpc = br_tgt[m_pc];
            else if (rtk) m_fpc = m_taddr + 1;
            else if (inl) m_fpc = m_fpc + 1;
            if (m_tpend) m_tpend = 0;
            if (cnd) begin
                m_wait = 1; m_tpend = 1; m_taddr = br_tgt[m_pc];
                wcnt = 0; cur_dly = br_dly[m_pc]; cur_tk = br_tk[m_pc];
            end else if (res) begin
                m_wait = 0;
                if (cc_taken) m_act = 1 - m_act;
            end
            if (!m_irv && m_stall < (1 << SW) - 1) m_stall++;
            spur_prev = spur;

            @(negedge clk);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule